// File: doc/BRIEF.md
# Transaction-Layer Packet Transmit Framer

This block turns a simple one-shot request into a transaction-layer packet on a 64-bit beat stream. A packet is one of three kinds: a memory read request, a memory write request, or a completion that carries exactly one qword of data. The caller raises one of three request strobes for a cycle. With the strobe it presents the qword address, the length in qwords, a tag, the local and remote identifiers and, for writes and completions, the first data qword. The framer captures the request and emits the packet one beat per cycle. Each beat carries flags for packet start, packet end, half beat (lower 32 bits unused) and valid. A ready input from the downstream sink holds the current beat in place.

Headers of three or four dwords are packed onto 64-bit beats. The header dword length, the byte-enable byte and the completion fields are all derived from the qword-based request. A read or write whose address has a non-zero upper word uses the four-dword form. Then the full address fills the second beat and payload qwords follow aligned. In the three-dword form, payload dwords straddle beat boundaries and the packet ends on a half beat. Write payload is pulled from the caller one qword at a time through a take strobe. A done pulse marks the final beat.

The control is a state machine with states IDLE, HDR, ADDR, DATA and TAIL. The transitions are:
- IDLE to HDR on a sampled strobe.
- HDR to ADDR.
- ADDR to IDLE for reads.
- ADDR to TAIL for completions and for short-form writes with no further qword to fetch.
- ADDR to DATA for long-form writes and for short-form writes with qwords still to fetch.
- DATA to DATA while qwords remain.
- DATA to TAIL in short form, or DATA to IDLE in long form, once all qwords have been fetched.
- TAIL to IDLE.

Every transition out of a non-idle state happens only on a cycle with ready high.

Top module: `tlp_tx_framer`

## Requirements
- R1: While idle, the beat data and all flags (start, end, half, valid, take, done) are zero. A strobe sampled at a clock edge while idle makes the header beat appear in the cycle after that edge.
- R2: The header dword length field (bits 41:32 of the first beat) equals twice the request length. The byte-enable byte (bits 7:0) is 0x0F for a length of one qword and 0xFF otherwise. A write header carries 0x00 in bits 15:8.
- R3: The first beat carries the start flag. Bits 63:32 hold header dword 0: bit 63 zero, format in 62:61 (00 short read, 01 long read, 10 short write, 11 long write), type 00000 in 60:56, zeros in 55:42. Bits 31:16 hold the local identifier. A read carries the tag, zero-extended to 8 bits, in bits 15:8.
- R4: When address bits 63:32 are non-zero, a read or write uses the long form. The second beat is the full byte address with bits 2:0 zero, and payload qwords follow whole, one per beat. The last beat has the end flag and no half flag.
- R5: A short-form read ends on its second beat. That beat holds byte address bits 31:3 followed by three zero bits in 63:32, and zero in 31:0, with the end and half flags set.
- R6: A short-form write puts byte address bits 31:3 followed by three zeros in 63:32 of the second beat, and the first qword's upper half in 31:0. Each later beat holds the previous qword's lower half above the next qword's upper half. The packet ends with a half beat holding the last qword's lower half above 32 zero bits.
- R7: Take pulses once per payload qword, on the beat at which the data input is consumed, and only with ready high. In the short form the first take is on the header beat. In the long form it is on the address beat. A completion never pulses take.
- R8: A completion header beat is 0x4A000002 in 63:32, the local identifier in 31:16, and byte count 8 with zero status and zero modified-count bit (0x0008) in 15:0.
- R9: The second completion beat holds the remote identifier (63:48), the zero-extended tag (47:40), a zero bit (39), byte address bits 6:3 and three zeros (38:32), and the data's upper half (31:0). A half beat with the data's lower half follows, with end and half set.
- R10: While valid is high and ready is low, the beat data and its start, end, half and valid flags are held unchanged.
- R11: Done is high exactly on the final beat of a packet in a cycle with ready high. The outputs are idle in the next cycle.
- R12: Strobes and request fields that change while a packet is in progress have no effect on the packet. A new request is sampled only once the block is idle again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_rd | input | 1 | Memory read request strobe |
| req_wr | input | 1 | Memory write request strobe |
| req_cpl | input | 1 | Completion request strobe |
| req_data | input | 64 | Payload qword (current write qword, or completion data at the strobe) |
| req_qaddr | input | 61 | Byte address bits 63:3 |
| req_qlen | input | LEN_W | Request length in qwords (1 or more) |
| req_tag | input | TAG_W | Transaction tag |
| local_id | input | 16 | Identifier of this function |
| remote_id | input | 16 | Requester identifier for completions |
| beat_ready | input | 1 | Sink accepts the current beat |
| beat_data | output | 64 | Beat contents |
| beat_sop | output | 1 | First beat of a packet |
| beat_eop | output | 1 | Last beat of a packet |
| beat_half | output | 1 | Only bits 63:32 of the beat are meaningful |
| beat_valid | output | 1 | A beat is present |
| data_take | output | 1 | req_data is consumed at this edge |
| pkt_done | output | 1 | Final beat is consumed at this edge |

## Verification
The hardest case to reach is a short-form write whose take pulses are interleaved with random back-pressure. Each qword must be replaced on the cycle after its take, and never during a stall. A feeder process therefore reacts only to a take that was seen with ready high. The bench runs a five-qword write and a completion while ready follows a pseudo-random sequence, and compares every held beat with its predecessor. Request hijack is provoked by holding the strobe and changing the address and tag one cycle into the packet.

// File: rtl/tlp_tx_pkg.sv
package tlp_tx_pkg;

    localparam int BEAT_W  = 64;
    localparam int HALF_W  = 32;
    localparam int QADDR_W = 61;
    localparam int ID_W    = 16;
    localparam int HI_LSB  = 29;   // qword address bit carrying byte address bit 32

    localparam logic [1:0] FMT_SHORT_ND = 2'b00;
    localparam logic [1:0] FMT_LONG_ND  = 2'b01;
    localparam logic [1:0] FMT_SHORT_D  = 2'b10;
    localparam logic [1:0] FMT_LONG_D   = 2'b11;
    localparam logic [4:0] TYPE_MEM     = 5'b00000;
    localparam logic [4:0] TYPE_CPL     = 5'b01010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_ADDR,
        ST_DATA,
        ST_TAIL
    } tx_state_e;

    typedef enum logic [1:0] {
        K_NONE,
        K_RD,
        K_WR,
        K_CPL
    } tx_kind_e;

endpackage

// File: rtl/tlp_req_capture.sv
module tlp_req_capture
    import tlp_tx_pkg::*;
#(
    parameter int LEN_W = 9,
    parameter int TAG_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  tx_kind_e           kind_in,
    input  logic [QADDR_W-1:0] qaddr_in,
    input  logic [LEN_W-1:0]   qlen_in,
    input  logic [TAG_W-1:0]   tag_in,
    input  logic [ID_W-1:0]    lid_in,
    input  logic [ID_W-1:0]    rid_in,
    output tx_kind_e           kind,
    output logic               is_long,
    output logic [QADDR_W-1:0] qaddr,
    output logic [LEN_W-1:0]   qlen,
    output logic [TAG_W-1:0]   tag,
    output logic [ID_W-1:0]    lid,
    output logic [ID_W-1:0]    rid
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind    <= K_NONE;
            is_long <= 1'b0;
            qaddr   <= '0;
            qlen    <= '0;
            tag     <= '0;
            lid     <= '0;
            rid     <= '0;
        end else if (start) begin
            kind    <= kind_in;
            is_long <= (kind_in != K_CPL) && (qaddr_in[QADDR_W-1:HI_LSB] != '0);
            qaddr   <= qaddr_in;
            qlen    <= qlen_in;
            tag     <= tag_in;
            lid     <= lid_in;
            rid     <= rid_in;
        end
    end

endmodule

// File: rtl/tlp_hdr_build.sv
module tlp_hdr_build
    import tlp_tx_pkg::*;
#(
    parameter int LEN_W = 9,
    parameter int TAG_W = 5
) (
    input  tx_kind_e           kind,
    input  logic               is_long,
    input  logic [LEN_W-1:0]   qlen,
    input  logic [TAG_W-1:0]   tag,
    input  logic [ID_W-1:0]    lid,
    input  logic [ID_W-1:0]    rid,
    input  logic [3:0]         lo_addr,
    output logic [BEAT_W-1:0]  hdr_beat,
    output logic [HALF_W-1:0]  cpl_w1
);

    localparam logic [11:0] CPL_BYTES = 12'd8;
    localparam logic [9:0]  CPL_DWLEN = 10'd2;

    logic [8:0]  qlen9;
    logic [7:0]  tag8;
    logic [7:0]  be;
    logic [1:0]  fmt;
    logic [4:0]  typ;
    logic [9:0]  dwlen;
    logic [31:0] dw1;

    assign qlen9 = 9'(qlen);
    assign tag8  = 8'(tag);
    assign be    = (qlen == LEN_W'(1)) ? 8'h0F : 8'hFF;

    always_comb begin
        fmt   = FMT_SHORT_ND;
        typ   = TYPE_MEM;
        dwlen = {qlen9, 1'b0};
        dw1   = '0;
        case (kind)
            K_RD: begin
                fmt = is_long ? FMT_LONG_ND : FMT_SHORT_ND;
                dw1 = {lid, tag8, be};
            end
            K_WR: begin
                fmt = is_long ? FMT_LONG_D : FMT_SHORT_D;
                dw1 = {lid, 8'h00, be};
            end
            K_CPL: begin
                fmt   = FMT_SHORT_D;
                typ   = TYPE_CPL;
                dwlen = CPL_DWLEN;
                dw1   = {lid, 3'b000, 1'b0, CPL_BYTES};
            end
            default: dwlen = '0;
        endcase
    end

    assign hdr_beat = {1'b0, fmt, typ, 8'h00, 6'h00, dwlen, dw1};
    assign cpl_w1   = {rid, tag8, 1'b0, lo_addr, 3'b000};

endmodule

// File: rtl/tlp_tx_ctrl.sv
module tlp_tx_ctrl
    import tlp_tx_pkg::*;
#(
    parameter int LEN_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_rd,
    input  logic               req_wr,
    input  logic               req_cpl,
    input  logic [BEAT_W-1:0]  req_data,
    input  logic [LEN_W-1:0]   req_qlen,
    input  logic               beat_ready,
    input  tx_kind_e           kind,
    input  logic               is_long,
    input  logic [QADDR_W-1:0] qaddr,
    input  logic [BEAT_W-1:0]  hdr_beat,
    input  logic [HALF_W-1:0]  cpl_w1,
    output logic               start,
    output tx_kind_e           new_kind,
    output logic [BEAT_W-1:0]  beat_data,
    output logic               beat_sop,
    output logic               beat_eop,
    output logic               beat_half,
    output logic               beat_valid,
    output logic               data_take,
    output logic               pkt_done
);

    tx_state_e          state_q, state_d;
    logic [LEN_W-1:0]   fetch_left_q;
    logic [BEAT_W-1:0]  cur_q;
    logic [HALF_W-1:0]  lo_q;
    logic               want_data;
    logic               last_beat;
    logic               advance;
    logic               more;

    assign more    = (fetch_left_q != '0);
    assign advance = beat_valid && beat_ready;

    always_comb begin
        if (req_rd)       new_kind = K_RD;
        else if (req_wr)  new_kind = K_WR;
        else if (req_cpl) new_kind = K_CPL;
        else              new_kind = K_NONE;
    end

    assign start = (state_q == ST_IDLE) && (new_kind != K_NONE);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_HDR;
            ST_HDR:  if (advance) state_d = ST_ADDR;
            ST_ADDR: if (advance) begin
                if (kind == K_RD)       state_d = ST_IDLE;
                else if (kind == K_CPL) state_d = ST_TAIL;
                else if (is_long)       state_d = ST_DATA;
                else                    state_d = more ? ST_DATA : ST_TAIL;
            end
            ST_DATA: if (advance) begin
                if (is_long) state_d = more ? ST_DATA : ST_IDLE;
                else         state_d = more ? ST_DATA : ST_TAIL;
            end
            ST_TAIL: if (advance) state_d = ST_IDLE;
        endcase
    end

    // state and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            fetch_left_q <= '0;
            cur_q        <= '0;
            lo_q         <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                fetch_left_q <= req_qlen;
                cur_q        <= (new_kind == K_CPL) ? req_data : '0;
                lo_q         <= '0;
            end else if (data_take) begin
                fetch_left_q <= fetch_left_q - 1'b1;
                lo_q         <= cur_q[HALF_W-1:0];
                cur_q        <= req_data;
            end
        end
    end

    // outputs
    always_comb begin
        beat_data  = '0;
        beat_sop   = 1'b0;
        beat_half  = 1'b0;
        beat_valid = 1'b0;
        want_data  = 1'b0;
        last_beat  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HDR: begin
                beat_valid = 1'b1;
                beat_sop   = 1'b1;
                beat_data  = hdr_beat;
                want_data  = (kind == K_WR) && !is_long && more;
            end
            ST_ADDR: begin
                beat_valid = 1'b1;
                case (kind)
                    K_RD: begin
                        last_beat = 1'b1;
                        beat_half = !is_long;
                        beat_data = is_long ? {qaddr, 3'b000}
                                            : {qaddr[HI_LSB-1:0], 3'b000, 32'h0};
                    end
                    K_WR: begin
                        want_data = more;
                        beat_data = is_long ? {qaddr, 3'b000}
                                            : {qaddr[HI_LSB-1:0], 3'b000, cur_q[BEAT_W-1:HALF_W]};
                    end
                    K_CPL:   beat_data = {cpl_w1, cur_q[BEAT_W-1:HALF_W]};
                    default: beat_data = '0;
                endcase
            end
            ST_DATA: begin
                beat_valid = 1'b1;
                want_data  = more;
                if (is_long) begin
                    beat_data = cur_q;
                    last_beat = !more;
                end else begin
                    beat_data = {lo_q, cur_q[BEAT_W-1:HALF_W]};
                end
            end
            ST_TAIL: begin
                beat_valid = 1'b1;
                beat_half  = 1'b1;
                last_beat  = 1'b1;
                beat_data  = {cur_q[HALF_W-1:0], 32'h0};
            end
        endcase
        beat_eop  = last_beat;
        data_take = want_data && beat_ready;
        pkt_done  = last_beat && beat_ready;
    end

endmodule

// File: rtl/tlp_tx_framer.sv
module tlp_tx_framer
    import tlp_tx_pkg::*;
#(
    parameter int LEN_W = 9,
    parameter int TAG_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_rd,
    input  logic               req_wr,
    input  logic               req_cpl,
    input  logic [63:0]        req_data,
    input  logic [60:0]        req_qaddr,
    input  logic [LEN_W-1:0]   req_qlen,
    input  logic [TAG_W-1:0]   req_tag,
    input  logic [15:0]        local_id,
    input  logic [15:0]        remote_id,
    input  logic               beat_ready,
    output logic [63:0]        beat_data,
    output logic               beat_sop,
    output logic               beat_eop,
    output logic               beat_half,
    output logic               beat_valid,
    output logic               data_take,
    output logic               pkt_done
);

    logic               start;
    tx_kind_e           new_kind;
    tx_kind_e           kind;
    logic               is_long;
    logic [QADDR_W-1:0] qaddr;
    logic [LEN_W-1:0]   qlen;
    logic [TAG_W-1:0]   tag;
    logic [ID_W-1:0]    lid;
    logic [ID_W-1:0]    rid;
    logic [BEAT_W-1:0]  hdr_beat;
    logic [HALF_W-1:0]  cpl_w1;

    tlp_req_capture #(.LEN_W(LEN_W), .TAG_W(TAG_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .kind_in  (new_kind),
        .qaddr_in (req_qaddr),
        .qlen_in  (req_qlen),
        .tag_in   (req_tag),
        .lid_in   (local_id),
        .rid_in   (remote_id),
        .kind     (kind),
        .is_long  (is_long),
        .qaddr    (qaddr),
        .qlen     (qlen),
        .tag      (tag),
        .lid      (lid),
        .rid      (rid)
    );

    tlp_hdr_build #(.LEN_W(LEN_W), .TAG_W(TAG_W)) u_hdr (
        .kind     (kind),
        .is_long  (is_long),
        .qlen     (qlen),
        .tag      (tag),
        .lid      (lid),
        .rid      (rid),
        .lo_addr  (qaddr[3:0]),
        .hdr_beat (hdr_beat),
        .cpl_w1   (cpl_w1)
    );

    tlp_tx_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_rd     (req_rd),
        .req_wr     (req_wr),
        .req_cpl    (req_cpl),
        .req_data   (req_data),
        .req_qlen   (req_qlen),
        .beat_ready (beat_ready),
        .kind       (kind),
        .is_long    (is_long),
        .qaddr      (qaddr),
        .hdr_beat   (hdr_beat),
        .cpl_w1     (cpl_w1),
        .start      (start),
        .new_kind   (new_kind),
        .beat_data  (beat_data),
        .beat_sop   (beat_sop),
        .beat_eop   (beat_eop),
        .beat_half  (beat_half),
        .beat_valid (beat_valid),
        .data_take  (data_take),
        .pkt_done   (pkt_done)
    );

endmodule

// File: rtl/tlp_tx_framer_chk.sv
module tlp_tx_framer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] beat_data,
    input logic        beat_sop,
    input logic        beat_eop,
    input logic        beat_half,
    input logic        beat_valid,
    input logic        beat_ready,
    input logic        data_take,
    input logic        pkt_done
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_valid |-> (beat_data == 64'h0) && !beat_sop && !beat_eop
                        && !beat_half && !data_take && !pkt_done);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_ready |=> beat_valid && $stable(beat_data)
            && $stable(beat_sop) && $stable(beat_eop) && $stable(beat_half));

    // R11
    done_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> beat_valid && beat_eop && beat_ready);

    // R11
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !beat_valid);

    // R7
    take_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_take |-> beat_valid && beat_ready && !beat_eop);

    // R5
    half_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_half |-> beat_eop && (beat_data[31:0] == 32'h0));

    // R3
    single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_sop && beat_ready |=> !beat_sop);

endmodule

bind tlp_tx_framer tlp_tx_framer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_data  (beat_data),
    .beat_sop   (beat_sop),
    .beat_eop   (beat_eop),
    .beat_half  (beat_half),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .data_take  (data_take),
    .pkt_done   (pkt_done)
);

// File: tb/tlp_tx_framer_tb.sv
module tlp_tx_framer_tb;

    localparam int LEN_W = 9;
    localparam int TAG_W = 5;
    localparam int KRD = 0, KWR = 1, KCPL = 2;

    typedef logic [63:0] qarr_t[];
    typedef struct {
        logic [63:0] d;
        logic sop, eop, half, take, done;
        string req;
    } beat_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_rd = 1'b0, req_wr = 1'b0, req_cpl = 1'b0;
    logic [63:0] req_data = '0;
    logic [60:0] req_qaddr = '0;
    logic [LEN_W-1:0] req_qlen = '0;
    logic [TAG_W-1:0] req_tag = '0;
    logic [15:0] local_id = '0, remote_id = '0;
    logic beat_ready = 1'b1;
    logic [63:0] beat_data;
    logic beat_sop, beat_eop, beat_half, beat_valid, data_take, pkt_done;

    always #5 clk = ~clk;

    tlp_tx_framer #(.LEN_W(LEN_W), .TAG_W(TAG_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
        .req_cpl(req_cpl), .req_data(req_data), .req_qaddr(req_qaddr),
        .req_qlen(req_qlen), .req_tag(req_tag), .local_id(local_id),
        .remote_id(remote_id), .beat_ready(beat_ready), .beat_data(beat_data),
        .beat_sop(beat_sop), .beat_eop(beat_eop), .beat_half(beat_half),
        .beat_valid(beat_valid), .data_take(data_take), .pkt_done(pkt_done)
    );

    beat_t       exp_q[$];
    logic [63:0] feed_mem[16];
    int          feed_len = 0;
    int          kick_req = 0;
    int          n_cmp = 0;
    int          n_bad = 0;
    logic        stall_mode = 1'b0;

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic pushb(input logic [63:0] d, input bit s, input bit e,
                         input bit h, input bit t, input bit dn, input string r);
        beat_t b;
        b.d = d; b.sop = s; b.eop = e; b.half = h; b.take = t; b.done = dn; b.req = r;
        exp_q.push_back(b);
    endtask

    function automatic qarr_t mk(input int n, input logic [63:0] seed);
        qarr_t a;
        a = new[n];
        foreach (a[i]) a[i] = {seed[63:32] ^ 32'(i * 32'h1111_0001), seed[31:0] + 32'(i * 7)};
        return a;
    endfunction

    // monitor / scoreboard / payload feeder
    initial begin
        logic [15:0] lfsr = 16'hACE1;
        int          kick_seen = 0;
        int          feed_idx = 0;
        bit          pend = 0;
        bit          prev_stall = 0;
        logic [63:0] prev_d = '0;
        logic [3:0]  prev_f = '0;
        beat_t       e;
        forever begin
            @(negedge clk);
            if (kick_req != kick_seen) begin
                kick_seen = kick_req;
                req_data  = (feed_len > 0) ? feed_mem[0] : 64'h0;
                feed_idx  = 1;
            end else if (pend) begin
                req_data = (feed_idx < feed_len) ? feed_mem[feed_idx] : 64'h0;
                feed_idx++;
            end
            pend = 0;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            beat_ready = stall_mode ? lfsr[0] : 1'b1;
            #1;
            if (rst_n) begin
                if (prev_stall) begin
                    // R10 held beat
                    check(beat_data == prev_d, "R10 data", beat_data, prev_d);
                    check({beat_sop, beat_eop, beat_half, beat_valid} == prev_f,
                          "R10 flags", 64'({beat_sop, beat_eop, beat_half, beat_valid}), 64'(prev_f));
                end
                if (!beat_valid) begin
                    // R1 idle outputs
                    check(beat_data == 64'h0, "R1 idle data", beat_data, 64'h0);
                    check({beat_sop, beat_eop, beat_half, data_take, pkt_done} == 5'b0,
                          "R1 idle flags", 64'({beat_sop, beat_eop, beat_half, data_take, pkt_done}), 64'h0);
                end else if (beat_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R12 unexpected beat", beat_data, 64'h0);
                    end else begin
                        e = exp_q.pop_front();
                        check(beat_data == e.d, e.req, beat_data, e.d);
                        check({beat_sop, beat_eop, beat_half} == {e.sop, e.eop, e.half},
                              {e.req, " flags"}, 64'({beat_sop, beat_eop, beat_half}),
                              64'({e.sop, e.eop, e.half}));
                        check(data_take == e.take, "R7 take", 64'(data_take), 64'(e.take));
                        check(pkt_done == e.done, "R11 done", 64'(pkt_done), 64'(e.done));
                    end
                    pend = data_take;
                end
                prev_stall = beat_valid && !beat_ready;
                prev_d     = beat_data;
                prev_f     = {beat_sop, beat_eop, beat_half, beat_valid};
            end
        end
    end

    // driver: builds the expected beats and issues the request
    task automatic send(input int kind, input logic [60:0] qa, input logic [8:0] ql,
                        input logic [4:0] tg, input logic [15:0] lid, input logic [15:0] rid,
                        input qarr_t d, input int hold);
        bit          lng;
        logic [9:0]  dwl;
        logic [7:0]  be;
        int          n;
        n   = int'(ql);
        lng = (kind != KCPL) && (qa[60:29] != 32'h0);
        dwl = {ql, 1'b0};
        be  = (ql == 9'd1) ? 8'h0F : 8'hFF;
        while (exp_q.size() != 0 || beat_valid) @(negedge clk);
        if (kind == KRD) begin
            pushb({1'b0, lng ? 2'b01 : 2'b00, 5'b0, 8'h0, 6'h0, dwl, lid, 3'b0, tg, be},
                  1, 0, 0, 0, 0, "R3 read header");
            if (lng) pushb({qa, 3'b000}, 0, 1, 0, 0, 1, "R4 long read addr");
            else     pushb({qa[28:0], 3'b000, 32'h0}, 0, 1, 1, 0, 1, "R5 short read addr");
        end else if (kind == KWR) begin
            pushb({1'b0, lng ? 2'b11 : 2'b10, 5'b0, 8'h0, 6'h0, dwl, lid, 8'h00, be},
                  1, 0, 0, !lng, 0, "R2 write header");
            if (lng) begin
                pushb({qa, 3'b000}, 0, 0, 0, 1, 0, "R4 long write addr");
                for (int i = 0; i < n; i++)
                    pushb(d[i], 0, i == n - 1, 0, i + 1 < n, i == n - 1, "R4 long payload");
            end else begin
                pushb({qa[28:0], 3'b000, d[0][63:32]}, 0, 0, 0, n > 1, 0, "R6 short write addr");
                for (int i = 1; i < n; i++)
                    pushb({d[i-1][31:0], d[i][63:32]}, 0, 0, 0, i + 1 < n, 0, "R6 straddle");
                pushb({d[n-1][31:0], 32'h0}, 0, 1, 1, 0, 1, "R6 tail");
            end
        end else begin
            pushb({1'b0, 2'b10, 5'b01010, 8'h0, 6'h0, 10'd2, lid, 16'h0008},
                  1, 0, 0, 0, 0, "R8 cpl header");
            pushb({rid, 3'b000, tg, 1'b0, qa[3:0], 3'b000, d[0][63:32]}, 0, 0, 0, 0, 0, "R9 cpl beat");
            pushb({d[0][31:0], 32'h0}, 0, 1, 1, 0, 1, "R9 cpl tail");
        end
        feed_len = d.size();
        foreach (d[i]) feed_mem[i] = d[i];
        kick_req++;
        @(negedge clk);
        req_rd = (kind == KRD); req_wr = (kind == KWR); req_cpl = (kind == KCPL);
        req_qaddr = qa; req_qlen = ql; req_tag = tg; local_id = lid; remote_id = rid;
        @(negedge clk);
        #2;
        // R1 header one cycle after the sampled strobe
        check(beat_valid && beat_sop, "R1 start latency", 64'({beat_valid, beat_sop}), 64'h3);
        if (hold > 1) begin
            // R12 strobe and fields disturbed while busy
            req_qaddr = ~qa; req_tag = ~tg; local_id = ~lid; remote_id = ~rid; req_qlen = 9'd7;
            repeat (hold - 1) @(negedge clk);
        end
        req_rd = 1'b0; req_wr = 1'b0; req_cpl = 1'b0;
        req_qaddr = '0; req_qlen = '0; req_tag = '0; local_id = '0; remote_id = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R11 watchdog", 64'(exp_q.size()), 64'h0);
        summary();
    end

    initial begin
        qarr_t none;
        none = new[0];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        send(KRD, 61'd1, 9'd1, 5'hA, 16'hAAAA, 16'h0, none, 1);
        send(KWR, 61'd2, 9'd2, 5'h0, 16'hBBBB, 16'h0, mk(2, 64'hBBBB_BBBB_BBBB_BBBB), 1);
        send(KCPL, 61'd3, 9'd0, 5'hC, 16'hAAAA, 16'hBBBB, mk(1, 64'hCCCC_CCCC_CCCC_CCCC), 1);
        send(KRD, {32'h0000_0001, 29'h0123_4567}, 9'd3, 5'hC, 16'hCCCC, 16'h0, none, 1);
        send(KWR, {32'h0000_0001, 29'h0000_0000}, 9'd1, 5'h0, 16'hAAAA, 16'h0, mk(1, 64'hAAAA_AAAA_AAAA_AAAA), 1);
        send(KWR, {32'h8000_0000, 29'h1000_0005}, 9'd3, 5'h0, 16'h1234, 16'h0, mk(3, 64'h0123_4567_89AB_CDEF), 1);
        send(KWR, 61'h0ABC_DEF0, 9'd1, 5'h0, 16'h5A5A, 16'h0, mk(1, 64'hDEAD_BEEF_F00D_CAFE), 1);
        stall_mode = 1'b1;
        send(KWR, 61'h1555_5555, 9'd5, 5'h0, 16'h0F0F, 16'h0, mk(5, 64'h1122_3344_5566_7788), 1);
        send(KRD, 61'h1FFF_FFFF, 9'd511, 5'h1F, 16'hFFFF, 16'h0, none, 1);
        send(KCPL, 61'h0000_002F, 9'd0, 5'h15, 16'h1357, 16'h2468, mk(1, 64'h9999_8888_7777_6666), 2);
        send(KRD, {32'h00F0_0000, 29'h0000_0010}, 9'd2, 5'h03, 16'h4242, 16'h0, none, 2);
        stall_mode = 1'b0;
        send(KWR, 61'h0000_0100, 9'd4, 5'h0, 16'h7777, 16'h0, mk(4, 64'h0F0F_F0F0_3C3C_C3C3), 2);
        while (exp_q.size() != 0 || beat_valid) @(negedge clk);
        repeat (4) @(negedge clk);
        summary();
    end

endmodule